// File: doc/BRIEF.md
# Watchdog Register Front End with Write Key

This block sits between a simple request bus and a two-stage watchdog countdown core. It decodes a 16-byte memory window and two configuration registers. It holds the two preload values, the control fields and a sticky flag that records that the previous reboot came from the watchdog. It drives these values into the core, emits a one-cycle reload pulse and returns read data one cycle after a read request.

Writes that change protected state are accepted only after a two-step key. Each key grants exactly one protected write. A lock register can freeze the enable and free-run controls until the next reset. The reboot-cause flag has its own power-on reset, so a normal reset leaves it unchanged.

Top module: `wdog_guard_regs`

## Requirements
- R1: After `rst_n` is released, both preloads read as all ones (0xFFFFF), enable, free-run and lock are 0, `reboot_en` is 1, `fast_clk` is 0, `irq_type` is 0, `reload_pulse` is 0 and `rd_data` is 0.
- R2: A memory write to offset 0xC whose size-masked value is 0x80 moves the key state to the half-open state from any state. A value of 0x86 at 0xC arms the key only from the half-open state. A 0x86 write in any other state grants nothing.
- R3: An armed 32-bit write (size code 2) to offset 0x0 loads the stage-one preload, and one to offset 0x4 loads the stage-two preload, each with the low 20 bits of the data. The same writes without the key change nothing.
- R4: Any 16-bit or 32-bit memory write that is not a key step returns the key state to idle, so one unlock allows exactly one protected write.
- R5: An armed 16-bit write (size code 1) to offset 0xC with data bit 8 set makes `reload_pulse` high for exactly one cycle. Without the key, no pulse is produced.
- R6: `reboot_event` sets the reboot-cause flag. An armed 16-bit write to 0xC with bit 9 or bit 12 set clears it. `rst_n` leaves the flag as it is, and only `por_n` clears it.
- R7: A 16-bit memory read of 0xC returns 0x1200 while the reboot-cause flag is set and 0 otherwise. Every other memory read returns 0.
- R8: Byte writes (size code 0) only advance the key. They never perform a protected action and never disarm the key.
- R9: In the lock register (config offset 0x68, byte access), bit 0 is lock, bit 1 is enable and bit 2 is free-run. The register reads back in the same layout. Once lock is set, writes to the register are ignored until reset.
- R10: The control register (config offset 0x60, 16-bit access) uses these fields: bit 5 set clears `reboot_en`, bit 2 sets `fast_clk`, and bits 1:0 give `irq_type`. It reads back in the same layout. Accesses of the wrong size neither write it nor read it; a wrong-size read returns 0.
- R11: `rd_data` changes only on the clock edge that samples a read request, and holds its value through idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset for all registers except the reboot-cause flag |
| por_n | input | 1 | Power-on reset, clears the reboot-cause flag |
| bus_valid | input | 1 | Request valid this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cfg | input | 1 | 1 = configuration space, 0 = memory window |
| bus_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| reboot_event | input | 1 | Core reports a stage-two expiry that rebooted |
| stage1_preload | output | 20 | Stage-one preload to core |
| stage2_preload | output | 20 | Stage-two preload to core |
| reload_pulse | output | 1 | One-cycle keep-alive to core |
| wd_enable | output | 1 | Countdown enable |
| wd_free_run | output | 1 | Restart stage one after stage two |
| wd_locked | output | 1 | Lock register frozen |
| reboot_en | output | 1 | Reboot on stage-two expiry |
| fast_clk | output | 1 | Fast tick scale selected |
| irq_type | output | 2 | Stage-one interrupt type |
| reboot_cause | output | 1 | Reboot-cause flag |

## Verification
The bench builds the block with its default parameters. These are a 20-bit preload, an 8-bit address, key values 0x80 and 0x86, and the key register at 0xC. With these values, masking of wide preload data, the all-ones reset preload and the 0x1200 readback all become visible at the ports. A vector table covers the key sequence against preloads, byte writes and misplaced key values. Directed tests then cover reload pulses, clearing of the reboot flag, the flag surviving `rst_n`, and the lock freeze.

// File: rtl/wdog_reg_pkg.sv
package wdog_reg_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} xfer_size_e;
  typedef enum logic [1:0] {KS_IDLE = 2'd0, KS_HALF = 2'd1, KS_ARMED = 2'd2} key_state_e;
  localparam int DATA_W = 32;

  function automatic logic [DATA_W-1:0] sized_value(input logic [1:0] sz, input logic [DATA_W-1:0] d);
    case (sz)
      SZ_BYTE: sized_value = {{(DATA_W-8){1'b0}}, d[7:0]};
      SZ_HALF: sized_value = {{(DATA_W-16){1'b0}}, d[15:0]};
      default: sized_value = d;
    endcase
  endfunction
endpackage

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_reg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] KEY_OFS = 'h0C,
  parameter logic [7:0] KEY_FIRST = 8'h80,
  parameter logic [7:0] KEY_SECOND = 8'h86
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_wr,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              grant
);
  key_state_e state_q, state_d;
  logic [DATA_W-1:0] val;
  logic at_key, is_first, is_second, consume;

  always_comb begin
    val       = sized_value(size, wdata);
    at_key    = (addr == KEY_OFS);
    is_first  = at_key && (val == {{(DATA_W-8){1'b0}}, KEY_FIRST});
    is_second = at_key && (val == {{(DATA_W-8){1'b0}}, KEY_SECOND}) && (state_q == KS_HALF);
    consume   = mem_wr && !is_first && !is_second && (size != SZ_BYTE);
    grant     = consume && (state_q == KS_ARMED);
  end

  always_comb begin
    state_d = state_q;
    if (mem_wr && is_first)       state_d = KS_HALF;
    else if (mem_wr && is_second) state_d = KS_ARMED;
    else if (consume)             state_d = KS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= state_d;
  end

  // R4: a consumed write always closes the key
  a_r4_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> (state_q == KS_IDLE));
  // R8: byte writes never disarm
  a_r8_byte_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && size == SZ_BYTE && state_q == KS_ARMED && !at_key) |=> (state_q == KS_ARMED));
  // R2: arming only from the half-open state
  a_r2_arm_order: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != KS_ARMED && state_q != KS_HALF) |=> (state_q != KS_ARMED));
endmodule

// File: rtl/wdog_prot_regs.sv
module wdog_prot_regs
  import wdog_reg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 20,
  parameter logic [ADDR_W-1:0] PRE1_OFS = 'h00,
  parameter logic [ADDR_W-1:0] PRE2_OFS = 'h04,
  parameter logic [ADDR_W-1:0] KEY_OFS  = 'h0C,
  parameter int RELOAD_BIT = 8,
  parameter int CLR_BIT_A  = 9,
  parameter int CLR_BIT_B  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              grant,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              reboot_event,
  output logic [CNT_W-1:0]  pre1,
  output logic [CNT_W-1:0]  pre2,
  output logic              reload,
  output logic              cause
);
  logic [CNT_W-1:0] pre1_q, pre2_q, pre1_d, pre2_d;
  logic ld1, ld2, ctl_wr, reload_d, cause_d;

  always_comb begin
    ld1      = grant && (size == SZ_WORD) && (addr == PRE1_OFS);
    ld2      = grant && (size == SZ_WORD) && (addr == PRE2_OFS);
    ctl_wr   = grant && (size == SZ_HALF) && (addr == KEY_OFS);
    pre1_d   = ld1 ? wdata[CNT_W-1:0] : pre1_q;
    pre2_d   = ld2 ? wdata[CNT_W-1:0] : pre2_q;
    reload_d = ctl_wr && wdata[RELOAD_BIT];
    cause_d  = cause;
    if (ctl_wr && (wdata[CLR_BIT_A] || wdata[CLR_BIT_B])) cause_d = 1'b0;
    if (reboot_event) cause_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre1_q <= '1;
      pre2_q <= '1;
      reload <= 1'b0;
    end else begin
      pre1_q <= pre1_d;
      pre2_q <= pre2_d;
      reload <= reload_d;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cause <= 1'b0;
    else        cause <= cause_d;
  end

  assign pre1 = pre1_q;
  assign pre2 = pre2_q;

  // R3: preloads move only on a granted word write
  a_r3_pre1_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |=> $stable(pre1_q));
  // R5: reload is a single-cycle pulse
  a_r5_pulse_once: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !reload);
  // R6: a reboot event always leaves the flag set
  a_r6_flag_set: assert property (@(posedge clk) disable iff (!por_n)
    reboot_event |=> cause);
endmodule

// File: rtl/wdog_ctl_regs.sv
module wdog_ctl_regs
  import wdog_reg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int INT_W  = 2,
  parameter logic [ADDR_W-1:0] CTL_OFS  = 'h60,
  parameter logic [ADDR_W-1:0] LOCK_OFS = 'h68,
  parameter int NOREBOOT_BIT = 5,
  parameter int FAST_BIT     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              enable,
  output logic              free_run,
  output logic              locked,
  output logic              reboot_en,
  output logic              fast_clk,
  output logic [INT_W-1:0]  irq_type
);
  logic ctl_hit, lock_hit;
  logic en_d, fr_d, lk_d, rb_d, fc_d;
  logic [INT_W-1:0] it_d;

  always_comb begin
    ctl_hit  = (addr == CTL_OFS) && (size == SZ_HALF);
    lock_hit = (addr == LOCK_OFS) && (size == SZ_BYTE);
    en_d = enable; fr_d = free_run; lk_d = locked;
    rb_d = reboot_en; fc_d = fast_clk; it_d = irq_type;
    if (cfg_wr && ctl_hit) begin
      rb_d = !wdata[NOREBOOT_BIT];
      fc_d = wdata[FAST_BIT];
      it_d = wdata[INT_W-1:0];
    end
    if (cfg_wr && lock_hit && !locked) begin
      lk_d = wdata[0];
      en_d = wdata[1];
      fr_d = wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0; free_run <= 1'b0; locked <= 1'b0;
      reboot_en <= 1'b1; fast_clk <= 1'b0; irq_type <= '0;
    end else begin
      enable <= en_d; free_run <= fr_d; locked <= lk_d;
      reboot_en <= rb_d; fast_clk <= fc_d; irq_type <= it_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (ctl_hit) begin
      cfg_rdata[NOREBOOT_BIT] = !reboot_en;
      cfg_rdata[FAST_BIT]     = fast_clk;
      cfg_rdata[INT_W-1:0]    = irq_type;
    end else if (lock_hit) begin
      cfg_rdata[2:0] = {free_run, enable, locked};
    end
  end

  // R9: lock never falls while out of reset
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  // R9: a frozen register ignores writes
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && cfg_wr && lock_hit) |=> ($stable(enable) && $stable(free_run)));
  // R10: control fields move only on a matching write
  a_r10_ctl_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && ctl_hit) |=> ($stable(reboot_en) && $stable(fast_clk) && $stable(irq_type)));
endmodule

// File: rtl/wdog_guard_regs.sv
module wdog_guard_regs
  import wdog_reg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 20,
  parameter int INT_W  = 2,
  parameter logic [7:0] KEY_FIRST  = 8'h80,
  parameter logic [7:0] KEY_SECOND = 8'h86
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_cfg,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       rd_data,
  input  logic              reboot_event,
  output logic [CNT_W-1:0]  stage1_preload,
  output logic [CNT_W-1:0]  stage2_preload,
  output logic              reload_pulse,
  output logic              wd_enable,
  output logic              wd_free_run,
  output logic              wd_locked,
  output logic              reboot_en,
  output logic              fast_clk,
  output logic [INT_W-1:0]  irq_type,
  output logic              reboot_cause
);
  localparam logic [ADDR_W-1:0] KEY_OFS = ADDR_W'('h0C);
  localparam int FLAG_BIT_A = 9;
  localparam int FLAG_BIT_B = 12;

  logic mem_wr, cfg_wr, rd_req, grant;
  logic [DATA_W-1:0] cfg_rdata, rd_d, rd_q;

  assign mem_wr = bus_valid && bus_write && !bus_cfg;
  assign cfg_wr = bus_valid && bus_write && bus_cfg;
  assign rd_req = bus_valid && !bus_write;

  wdog_key_seq #(.ADDR_W(ADDR_W), .KEY_OFS(KEY_OFS), .KEY_FIRST(KEY_FIRST),
                 .KEY_SECOND(KEY_SECOND)) u_key (
    .clk(clk), .rst_n(rst_n), .mem_wr(mem_wr), .size(bus_size),
    .addr(bus_addr), .wdata(bus_wdata), .grant(grant));

  wdog_prot_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .KEY_OFS(KEY_OFS),
                   .CLR_BIT_A(FLAG_BIT_A), .CLR_BIT_B(FLAG_BIT_B)) u_prot (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .grant(grant), .size(bus_size),
    .addr(bus_addr), .wdata(bus_wdata), .reboot_event(reboot_event),
    .pre1(stage1_preload), .pre2(stage2_preload), .reload(reload_pulse),
    .cause(reboot_cause));

  wdog_ctl_regs #(.ADDR_W(ADDR_W), .INT_W(INT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .size(bus_size),
    .addr(bus_addr), .wdata(bus_wdata), .cfg_rdata(cfg_rdata),
    .enable(wd_enable), .free_run(wd_free_run), .locked(wd_locked),
    .reboot_en(reboot_en), .fast_clk(fast_clk), .irq_type(irq_type));

  always_comb begin
    rd_d = '0;
    if (bus_cfg) rd_d = cfg_rdata;
    else if (bus_addr == KEY_OFS && bus_size == SZ_HALF) begin
      rd_d[FLAG_BIT_A] = reboot_cause;
      rd_d[FLAG_BIT_B] = reboot_cause;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (rd_req) rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  // R11: read data holds without a read request
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> $stable(rd_q));
  // R7: memory reads only ever show the two flag bits
  a_r7_mem_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !bus_cfg) |=> ((rd_q & ~32'h1200) == 32'h0));
endmodule

// File: tb/sim_wdog_guard_regs.sv
module sim_wdog_guard_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, bus_cfg = 1'b0;
  logic [1:0] bus_size = 2'd0;
  logic [7:0] bus_addr = 8'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic reboot_event = 1'b0;
  logic [31:0] rd_data;
  logic [19:0] pre1, pre2;
  logic reload_pulse, wd_enable, wd_free_run, wd_locked, reboot_en, fast_clk, reboot_cause;
  logic [1:0] irq_type;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  wdog_guard_regs u0 (.clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_cfg(bus_cfg), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .reboot_event(reboot_event),
    .stage1_preload(pre1), .stage2_preload(pre2), .reload_pulse(reload_pulse),
    .wd_enable(wd_enable), .wd_free_run(wd_free_run), .wd_locked(wd_locked),
    .reboot_en(reboot_en), .fast_clk(fast_clk), .irq_type(irq_type),
    .reboot_cause(reboot_cause));

  // entry: kind(2) size(2) addr(8) data(32) what(2) expect(32) req(4)
  // kind 0 mem wr, 1 mem rd, 2 cfg wr, 3 cfg rd; what 0 none, 1 rd_data, 2 pre1, 3 pre2
  localparam int NV = 21;
  localparam logic [81:0] VEC [NV] = '{
    {2'd0, 2'd2, 8'h00, 32'h00000123, 2'd2, 32'h000FFFFF, 4'd3},  // R3 no key
    {2'd0, 2'd1, 8'h0C, 32'h00000080, 2'd0, 32'h0, 4'd2},
    {2'd0, 2'd1, 8'h0C, 32'h00000086, 2'd0, 32'h0, 4'd2},
    {2'd0, 2'd2, 8'h00, 32'hABC12345, 2'd2, 32'h00012345, 4'd3},  // R3 masked
    {2'd0, 2'd2, 8'h04, 32'h00000777, 2'd3, 32'h000FFFFF, 4'd4},  // R4 one write
    {2'd0, 2'd0, 8'h0C, 32'h00000080, 2'd0, 32'h0, 4'd8},
    {2'd0, 2'd0, 8'h0C, 32'h00000086, 2'd0, 32'h0, 4'd8},
    {2'd0, 2'd0, 8'h04, 32'h00000055, 2'd3, 32'h000FFFFF, 4'd8},  // R8 no action
    {2'd0, 2'd2, 8'h04, 32'h00054321, 2'd3, 32'h00054321, 4'd8},  // R8 still armed
    {2'd0, 2'd2, 8'h0C, 32'h00000086, 2'd0, 32'h0, 4'd2},
    {2'd0, 2'd2, 8'h04, 32'h00000001, 2'd3, 32'h00054321, 4'd2},  // R2 lone 0x86
    {2'd1, 2'd1, 8'h0C, 32'h0, 2'd1, 32'h00000000, 4'd7},         // R7 flag clear
    {2'd2, 2'd1, 8'h60, 32'h00000026, 2'd0, 32'h0, 4'd10},
    {2'd3, 2'd1, 8'h60, 32'h0, 2'd1, 32'h00000026, 4'd10},        // R10 readback
    {2'd2, 2'd0, 8'h60, 32'h00000001, 2'd0, 32'h0, 4'd10},
    {2'd3, 2'd1, 8'h60, 32'h0, 2'd1, 32'h00000026, 4'd10},        // R10 wrong size
    {2'd2, 2'd0, 8'h68, 32'h00000006, 2'd0, 32'h0, 4'd9},
    {2'd3, 2'd0, 8'h68, 32'h0, 2'd1, 32'h00000006, 4'd9},         // R9 fields
    {2'd2, 2'd0, 8'h68, 32'h00000007, 2'd0, 32'h0, 4'd9},
    {2'd2, 2'd0, 8'h68, 32'h00000000, 2'd0, 32'h0, 4'd9},
    {2'd3, 2'd0, 8'h68, 32'h0, 2'd1, 32'h00000007, 4'd9}          // R9 frozen
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic [1:0] kind, input logic [1:0] sz, input logic [7:0] a,
                        input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = !kind[0]; bus_cfg = kind[1];
    bus_size = sz; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic arm();
    bus_op(2'd0, 2'd1, 8'h0C, 32'h80);
    bus_op(2'd0, 2'd1, 8'h0C, 32'h86);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (2) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pre1", {12'd0, pre1}, 32'hFFFFF);
    check("R1 pre2", {12'd0, pre2}, 32'hFFFFF);
    check("R1 ctl", {24'd0, wd_enable, wd_free_run, wd_locked, reboot_en, fast_clk,
                     irq_type, reload_pulse}, 32'h10);
    check("R1 rd", rd_data, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [81:0] v;
      v = VEC[i];
      bus_op(v[81:80], v[79:78], v[77:70], v[69:38]);
      case (v[37:36])
        2'd1: check($sformatf("R%0d vec %0d rd", v[3:0], i), rd_data, v[35:4]);
        2'd2: check($sformatf("R%0d vec %0d pre1", v[3:0], i), {12'd0, pre1}, v[35:4]);
        2'd3: check($sformatf("R%0d vec %0d pre2", v[3:0], i), {12'd0, pre2}, v[35:4]);
        default: ;
      endcase
    end
    check("R10 fields", {29'd0, reboot_en, fast_clk, irq_type[1]}, 32'h3);
    check("R9 outputs", {29'd0, wd_locked, wd_enable, wd_free_run}, 32'h7);

    // R5 reload without key: no pulse
    bus_op(2'd0, 2'd1, 8'h0C, 32'h100);
    check("R5 no key", {31'd0, reload_pulse}, 32'h0);
    // R5 armed reload: one cycle
    arm();
    bus_op(2'd0, 2'd1, 8'h0C, 32'h100);
    check("R5 pulse", {31'd0, reload_pulse}, 32'h1);
    @(negedge clk);
    check("R5 pulse end", {31'd0, reload_pulse}, 32'h0);

    // R6 / R7 flag set and readback
    reboot_event = 1'b1; @(negedge clk); reboot_event = 1'b0;
    bus_op(2'd1, 2'd1, 8'h0C, 32'h0);
    check("R7 flag read", rd_data, 32'h1200);
    bus_op(2'd1, 2'd2, 8'h0C, 32'h0);
    check("R7 word read", rd_data, 32'h0);
    bus_op(2'd1, 2'd1, 8'h0C, 32'h0);
    held = rd_data;
    repeat (3) @(negedge clk);
    check("R11 hold", rd_data, held);

    // R6 survives rst_n; R1/R9 lock cleared
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    check("R9 unlocked after reset", {31'd0, wd_locked}, 32'h0);
    bus_op(2'd1, 2'd1, 8'h0C, 32'h0);
    check("R6 kept", rd_data, 32'h1200);
    // R6 clear by bit 9 requires key
    bus_op(2'd0, 2'd1, 8'h0C, 32'h200);
    bus_op(2'd1, 2'd1, 8'h0C, 32'h0);
    check("R6 no key", rd_data, 32'h1200);
    arm();
    bus_op(2'd0, 2'd1, 8'h0C, 32'h200);
    bus_op(2'd1, 2'd1, 8'h0C, 32'h0);
    check("R6 clr bit9", rd_data, 32'h0);
    reboot_event = 1'b1; @(negedge clk); reboot_event = 1'b0;
    arm();
    bus_op(2'd0, 2'd1, 8'h0C, 32'h1000);
    bus_op(2'd1, 2'd1, 8'h0C, 32'h0);
    check("R6 clr bit12", rd_data, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule